// File: doc/BRIEF.md
# Bouncing Three-Lamp Sweep Sequencer

This block drives three lamp outputs (left, middle, right) so that a single lit lamp appears to travel from the left end to the right end and then back again, without stopping. It is a Moore machine. The lamp outputs are held in registers and depend only on the machine's position, never directly on an input.

A step-enable input sets the pace. Each clock edge with the enable high moves the light one position. With the enable tied high, the clock rate alone sets the speed of the sweep. A slower pace comes from an external tick pulse on the enable.

The middle lamp is lit both on the way out and on the way back. For this reason the machine tracks four positions for three lamps, using a 2-bit position register. The two middle positions differ only in the direction of travel.

Top module: `lamp_sweep`

## Requirements
- R1: While the active-low reset is asserted, and after release until the first enabled step, only the left lamp is lit. The lamp bus {left, middle, right} reads 100.
- R2: Out of reset, exactly one of the three lamp outputs is high on every cycle.
- R3: Each enabled step from the left lamp lights the middle lamp (100 -> 010). Each enabled step from the right lamp also lights the middle lamp (001 -> 010).
- R4: On a clock edge where the step enable is low, the lamp outputs and the direction of travel stay unchanged.
- R5: Leaving the middle lamp, the light keeps its direction of travel. If it arrived from the left it goes to the right (010 -> 001). If it arrived from the right it goes to the left (010 -> 100).
- R6: With the enable held high, the lamp bus repeats the four-step cycle 100, 010, 001, 010 after reset. The light returns to 100 every fourth step.
- R7: Asserting reset during a sweep forces the lamp bus to 100 at once, without waiting for a clock edge. The next enabled step after release lights the middle lamp, travelling rightward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the light moves only on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the light on this edge when high |
| lamp_left | output | 1 | Left lamp, registered |
| lamp_middle | output | 1 | Middle lamp, registered |
| lamp_right | output | 1 | Right lamp, registered |

## Verification
The assertions assume three things: step_en is a clean level sampled at the rising clock edge, reset is the only way to force a position, and reset is applied before the first check. The stimulus follows all three. It changes step_en and releases reset only on falling clock edges. It pulls reset low once at the start, before any step. The mid-sweep reset is applied between edges, with no enabled edge falling inside the reset window.

// File: rtl/lamp_sweep_pkg.sv
package lamp_sweep_pkg;

    localparam int LAMP_N  = 3;
    localparam int STATE_W = 2;

    typedef logic [LAMP_N-1:0] lamp_t;

    // Lamp bus order is {left, middle, right}
    localparam lamp_t LIT_LEFT   = lamp_t'(1) << (LAMP_N - 1);
    localparam lamp_t LIT_MIDDLE = lamp_t'(1) << (LAMP_N / 2);
    localparam lamp_t LIT_RIGHT  = lamp_t'(1);

    typedef enum logic [STATE_W-1:0] {
        POS_LEFT     = 2'd0,
        POS_MID_OUT  = 2'd1,
        POS_RIGHT    = 2'd2,
        POS_MID_BACK = 2'd3
    } pos_e;

    typedef struct packed {
        pos_e  pos;
        lamp_t lamps;
    } sweep_reg_t;

endpackage

// File: rtl/sweep_next.sv
module sweep_next
    import lamp_sweep_pkg::*;
(
    input  pos_e pos_q,
    input  logic step_en,
    output pos_e pos_d
);

    always_comb begin
        pos_d = pos_q;
        if (step_en) begin
            unique case (pos_q)
                POS_LEFT:     pos_d = POS_MID_OUT;
                POS_MID_OUT:  pos_d = POS_RIGHT;
                POS_RIGHT:    pos_d = POS_MID_BACK;
                POS_MID_BACK: pos_d = POS_LEFT;
                default:      pos_d = POS_LEFT;
            endcase
        end
    end

endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
    import lamp_sweep_pkg::*;
(
    input  pos_e  pos,
    output lamp_t lamps
);

    always_comb begin
        unique case (pos)
            POS_LEFT:     lamps = LIT_LEFT;
            POS_MID_OUT:  lamps = LIT_MIDDLE;
            POS_RIGHT:    lamps = LIT_RIGHT;
            POS_MID_BACK: lamps = LIT_MIDDLE;
            default:      lamps = LIT_LEFT;
        endcase
    end

endmodule

// File: rtl/lamp_sweep.sv
module lamp_sweep
    import lamp_sweep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    output logic lamp_left,
    output logic lamp_middle,
    output logic lamp_right
);

    sweep_reg_t sweep_d, sweep_q;
    pos_e       pos_next;
    lamp_t      lamps_next;

    sweep_next u_next (
        .pos_q   (sweep_q.pos),
        .step_en (step_en),
        .pos_d   (pos_next)
    );

    // Decode from the next position so the lamps register in step with it
    lamp_decode u_decode (
        .pos   (pos_next),
        .lamps (lamps_next)
    );

    always_comb begin
        sweep_d       = sweep_q;
        sweep_d.pos   = pos_next;
        sweep_d.lamps = lamps_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_q <= '{pos: POS_LEFT, lamps: LIT_LEFT};
        end else begin
            sweep_q <= sweep_d;
        end
    end

    assign {lamp_left, lamp_middle, lamp_right} = sweep_q.lamps;

    // R1: reset value seen at every edge while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_left: assert (sweep_q.lamps == LIT_LEFT && sweep_q.pos == POS_LEFT);
        end
    end

    a_r2_single_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lamp_left, lamp_middle, lamp_right}) == 1);

    a_r3_left_to_middle: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && sweep_q.lamps == LIT_LEFT) |=> (sweep_q.lamps == LIT_MIDDLE));

    a_r3_right_to_middle: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && sweep_q.lamps == LIT_RIGHT) |=> (sweep_q.lamps == LIT_MIDDLE));

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(sweep_q.lamps) && $stable(sweep_q.pos)));

    a_r5_outward_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && sweep_q.pos == POS_MID_OUT) |=> (sweep_q.lamps == LIT_RIGHT));

    a_r5_return_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && sweep_q.pos == POS_MID_BACK) |=> (sweep_q.lamps == LIT_LEFT));

endmodule

// File: tb/lamp_sweep_bench.sv
module lamp_sweep_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic step_en = 1'b0;
    logic lamp_left, lamp_middle, lamp_right;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lamp_sweep u_lamp_sweep (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .lamp_left   (lamp_left),
        .lamp_middle (lamp_middle),
        .lamp_right  (lamp_right)
    );

    // Each entry: {step_en, expected lamp bus {left, middle, right} after that edge}
    localparam int NVEC = 16;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1_010, 4'b1_001, 4'b1_010, 4'b1_100,
        4'b1_010, 4'b1_001, 4'b1_010, 4'b1_100,
        4'b0_100, 4'b1_010, 4'b0_010, 4'b0_010,
        4'b1_001, 4'b0_001, 4'b1_010, 4'b1_100
    };

    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {lamp_left, lamp_middle, lamp_right};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: lamps=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_one_hot();
        n_checks++;
        if ($countones({lamp_left, lamp_middle, lamp_right}) != 1) begin
            n_fails++;
            $display("FAIL R2: lamps=%b expected one lamp lit", {lamp_left, lamp_middle, lamp_right});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        #1 rst_n = 1'b0;
        step_en = 1'b1;
        // R1: held in reset across edges even with enable high
        repeat (3) @(negedge clk);
        chk("R1 reset held", 3'b100);
        rst_n = 1'b0;
        step_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 3'b100);

        // R3, R4, R5, R6 from the vector table; the first 8 cover the full window
        for (int i = 0; i < NVEC; i++) begin
            step_en = VEC[i][3];
            @(negedge clk);
            if (!VEC[i][3]) chk("R4 hold", VEC[i][2:0]);
            else if (i < 8) chk("R6 sweep window", VEC[i][2:0]);
            else chk("R3 R5 step", VEC[i][2:0]);
            chk_one_hot();
        end

        // R5: direction held through a long pause at the middle going right
        step_en = 1'b1;
        @(negedge clk);
        chk("R3 to middle", 3'b010);
        step_en = 1'b0;
        repeat (5) @(negedge clk);
        chk("R4 long pause", 3'b010);
        step_en = 1'b1;
        @(negedge clk);
        chk("R5 outward", 3'b001);
        @(negedge clk);
        chk("R3 from right", 3'b010);
        step_en = 1'b0;
        repeat (3) @(negedge clk);
        step_en = 1'b1;
        @(negedge clk);
        chk("R5 return", 3'b100);
        @(negedge clk);
        @(negedge clk);
        chk("R6 right end", 3'b001);

        // R7: asynchronous reset mid-sweep, between edges
        step_en = 1'b0;
        #2 rst_n = 1'b0;
        #1 chk("R7 immediate reset", 3'b100);
        @(negedge clk);
        rst_n = 1'b1;
        step_en = 1'b1;
        @(negedge clk);
        chk("R7 restart rightward", 3'b010);
        @(negedge clk);
        chk("R7 continues right", 3'b001);
        chk_one_hot();

        finish_run();
    end

endmodule